// File: doc/BRIEF.md
# Handshaked Fuzzy-Input Acquisition Port

This block collects up to eight 8-bit crisp input values from an external byte bus and keeps them in a register file for a fuzzy inference core. Each byte comes in through a request/acknowledge handshake. The host raises the request strobe, and the port answers on its acknowledge line once the byte has been latched. When acquisition is complete, the port raises busy so the core can start elaboration. When the core pulses done, the port lowers busy and opens a new acquisition round.

There are two acquisition orders. In sequential (master) order the bytes are written to slots 0, 1, 2 and onward. The port shows the slot it expects next, and it starts elaboration once the configured number of bytes has arrived. In addressed (slave) order the host sends a 3-bit slot number with every byte, and the bytes may come in any order. The host ends the round with a last-input strobe. Slots that are not written in a round keep their previous contents, so slowly changing inputs do not have to be sent again. Each of the four handshake lines has its own polarity bit.

The controller is a four-state machine:
- `ST_OFFL`: held while the offline level is high.
- `ST_GUARD`: a dead time after the offline level falls.
- `ST_ACQ`: bytes are accepted.
- `ST_ELAB`: busy, waiting for done.

Transitions:
- OFFL→GUARD when offline is low.
- GUARD→ACQ after three guard cycles.
- ACQ→ELAB on the final sequential byte, or on the last-input strobe in addressed order.
- ELAB→ACQ on done.
- Any state→OFFL when offline is high.

Top module: `fzin_port`

## Requirements
- R1: After reset, the acknowledge and busy outputs are inactive, the next-slot index is 0 and every stored byte is 0.
- R2: A request edge is not accepted while offline is high or during the guard time after offline falls. Acceptance becomes possible 4 clock edges after the first edge that samples offline low. A refused request produces no acknowledge and stores nothing.
- R3: An accepted request edge is sampled at clock edge E0. Acknowledge becomes active after edge E0+1, not after E0. It returns to inactive on the first edge that samples the request inactive.
- R4: With mode = 1 (sequential order), bytes are stored into slots 0 to count-1 in arrival order. `next_idx_o` shows the slot for the next byte.
- R5: In sequential order, the byte accepted with `next_idx_o` equal to `cfg_cnt_m1_i` makes busy active. On that same edge `next_idx_o` wraps to 0. `cfg_cnt_m1_i` is the input count minus one, so values 0 to 7 mean 1 to 8 inputs.
- R6: With mode = 0 (addressed order), each byte is stored in the slot named by `sel_i`, which is sampled together with the byte. Any order is allowed.
- R7: In addressed order, an active last-input strobe in the acquisition state makes busy active on the next edge. Slots not written in the round keep their earlier values.
- R8: Request edges while busy is active are ignored. No acknowledge is given and no slot changes.
- R9: A done pulse while busy makes busy inactive on the next edge and reopens acquisition, with `next_idx_o` at 0.
- R10: `cfg_pol_i` sets the polarity of each handshake line, with 1 meaning active high and 0 meaning active low. The bits are: bit 0 acknowledge, bit 1 request, bit 2 last-input, bit 3 busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| offline_i | input | 1 | High while configuration download is running; halts acquisition |
| cfg_master_i | input | 1 | 1 = sequential order, 0 = addressed order |
| cfg_cnt_m1_i | input | 3 | Number of inputs minus one |
| cfg_pol_i | input | 4 | Polarity per line: [0] ack, [1] request, [2] last, [3] busy |
| rd_i | input | 1 | Request strobe, byte valid on data_i |
| sel_i | input | 3 | Slot number for addressed order |
| data_i | input | 8 | Input byte |
| last_i | input | 1 | Last-input strobe (addressed order) |
| done_i | input | 1 | Core finished elaboration, active high |
| ready_o | output | 1 | Acknowledge strobe |
| busy_o | output | 1 | Elaboration in progress |
| next_idx_o | output | 3 | Slot expected next in sequential order |
| var_o | output | 64 | Stored bytes, slot k at bits [8k+7:8k] |

## Verification
The assertions assume the configuration inputs stay constant during an acquisition round. They also assume `sel_i` and `data_i` are stable in the cycle that the request edge is sampled. Mode, count and polarity are changed only while the port is idle. The bench changes these settings only when busy is inactive and no request is in progress, and it holds each request active until the acknowledge is checked. The bench flips the request line together with a polarity change so that the change does not create a false edge.

// File: rtl/fzin_pkg.sv
package fzin_pkg;
    typedef enum logic [1:0] {
        ST_OFFL  = 2'd0,
        ST_GUARD = 2'd1,
        ST_ACQ   = 2'd2,
        ST_ELAB  = 2'd3
    } acq_state_e;

    localparam int POL_ACK  = 0;
    localparam int POL_REQ  = 1;
    localparam int POL_LAST = 2;
    localparam int POL_BUSY = 3;
    localparam int POL_W    = 4;
endpackage

// File: rtl/fzin_pol.sv
module fzin_pol #(
    parameter int N = 2
) (
    input  logic [N-1:0] sig_i,
    input  logic [N-1:0] pol_i,
    output logic [N-1:0] sig_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        assign sig_o[g] = ~(sig_i[g] ^ pol_i[g]);
    end
endmodule

// File: rtl/fzin_regfile.sv
module fzin_regfile #(
    parameter int NVARS = 8,
    parameter int DW    = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [$clog2(NVARS)-1:0] wr_idx_i,
    input  logic [DW-1:0]         wr_data_i,
    output logic [NVARS*DW-1:0]   vars_o
);
    localparam int IW = $clog2(NVARS);

    for (genvar g = 0; g < NVARS; g++) begin : g_slot
        logic [DW-1:0] slot_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (wr_en_i && (wr_idx_i == IW'(g))) begin
                slot_q <= wr_data_i;
            end
        end
        assign vars_o[g*DW +: DW] = slot_q;
    end

    AST_HOLD_UNWRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(vars_o)); // R7
endmodule

// File: rtl/fzin_ctrl.sv
module fzin_ctrl
    import fzin_pkg::*;
#(
    parameter int NVARS     = 8,
    parameter int GUARD_CYC = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     offline_i,
    input  logic                     master_i,
    input  logic [$clog2(NVARS)-1:0] cnt_m1_i,
    input  logic                     req_act_i,
    input  logic                     last_act_i,
    input  logic [$clog2(NVARS)-1:0] sel_i,
    input  logic                     done_i,
    output logic                     wr_en_o,
    output logic [$clog2(NVARS)-1:0] wr_idx_o,
    output logic                     ack_o,
    output logic                     busy_o,
    output logic [$clog2(NVARS)-1:0] next_idx_o
);
    localparam int IW = $clog2(NVARS);
    localparam int GW = $clog2(GUARD_CYC + 1);

    acq_state_e      state_q, state_d;
    logic [GW-1:0]   gcnt_q;
    logic [IW-1:0]   nxt_q;
    logic            req_prev_q;
    logic            pend_q;
    logic            ack_q;
    logic            accept;
    logic            final_seq;

    assign accept    = req_act_i && !req_prev_q && (state_q == ST_ACQ);
    assign final_seq = accept && master_i && (nxt_q == cnt_m1_i);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFFL: begin
                if (!offline_i) state_d = ST_GUARD;
            end
            ST_GUARD: begin
                if (offline_i) state_d = ST_OFFL;
                else if (gcnt_q == GW'(GUARD_CYC - 1)) state_d = ST_ACQ;
            end
            ST_ACQ: begin
                if (offline_i) state_d = ST_OFFL;
                else if (final_seq) state_d = ST_ELAB;
                else if (!master_i && last_act_i) state_d = ST_ELAB;
            end
            ST_ELAB: begin
                if (offline_i) state_d = ST_OFFL;
                else if (done_i) state_d = ST_ACQ;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_OFFL;
            gcnt_q     <= '0;
            nxt_q      <= '0;
            req_prev_q <= 1'b0;
            pend_q     <= 1'b0;
            ack_q      <= 1'b0;
        end else begin
            state_q    <= state_d;
            req_prev_q <= req_act_i;
            pend_q     <= accept;
            ack_q      <= pend_q || (ack_q && req_act_i);
            if (state_q == ST_GUARD) gcnt_q <= gcnt_q + GW'(1);
            else                     gcnt_q <= '0;
            if (accept && master_i) begin
                nxt_q <= final_seq ? '0 : nxt_q + IW'(1);
            end else if (state_q == ST_OFFL) begin
                nxt_q <= '0;
            end
        end
    end

    always_comb begin
        wr_en_o    = accept;
        wr_idx_o   = master_i ? nxt_q : sel_i;
        ack_o      = ack_q;
        busy_o     = (state_q == ST_ELAB);
        next_idx_o = nxt_q;
    end

    AST_ACK_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ##2 ack_q); // R3
    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && req_act_i && !req_prev_q) |=> !pend_q); // R8
    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (master_i && state_q == ST_ACQ) |-> (next_idx_o <= cnt_m1_i)); // R4
    AST_WRAP_ON_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy_o) && master_i) |-> (next_idx_o == '0)); // R5
    AST_GUARD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACQ) |-> (!$past(offline_i, 1) && !$past(offline_i, 2)
                                 && !$past(offline_i, 3))); // R2
endmodule

// File: rtl/fzin_port.sv
module fzin_port
    import fzin_pkg::*;
#(
    parameter int NVARS = 8,
    parameter int DW    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     offline_i,
    input  logic                     cfg_master_i,
    input  logic [$clog2(NVARS)-1:0] cfg_cnt_m1_i,
    input  logic [POL_W-1:0]         cfg_pol_i,
    input  logic                     rd_i,
    input  logic [$clog2(NVARS)-1:0] sel_i,
    input  logic [DW-1:0]            data_i,
    input  logic                     last_i,
    input  logic                     done_i,
    output logic                     ready_o,
    output logic                     busy_o,
    output logic [$clog2(NVARS)-1:0] next_idx_o,
    output logic [NVARS*DW-1:0]      var_o
);
    localparam int IW = $clog2(NVARS);

    logic [1:0]    in_act;
    logic [1:0]    out_int;
    logic [1:0]    out_pin;
    logic          wr_en;
    logic [IW-1:0] wr_idx;

    fzin_pol #(.N(2)) u_in_pol (
        .sig_i ({last_i, rd_i}),
        .pol_i ({cfg_pol_i[POL_LAST], cfg_pol_i[POL_REQ]}),
        .sig_o (in_act)
    );

    fzin_ctrl #(.NVARS(NVARS), .GUARD_CYC(3)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .offline_i  (offline_i),
        .master_i   (cfg_master_i),
        .cnt_m1_i   (cfg_cnt_m1_i),
        .req_act_i  (in_act[0]),
        .last_act_i (in_act[1]),
        .sel_i      (sel_i),
        .done_i     (done_i),
        .wr_en_o    (wr_en),
        .wr_idx_o   (wr_idx),
        .ack_o      (out_int[0]),
        .busy_o     (out_int[1]),
        .next_idx_o (next_idx_o)
    );

    fzin_regfile #(.NVARS(NVARS), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (data_i),
        .vars_o    (var_o)
    );

    fzin_pol #(.N(2)) u_out_pol (
        .sig_i (out_int),
        .pol_i ({cfg_pol_i[POL_BUSY], cfg_pol_i[POL_ACK]}),
        .sig_o (out_pin)
    );

    assign ready_o = out_pin[0];
    assign busy_o  = out_pin[1];
endmodule

// File: tb/fzin_port_tb_top.sv
module fzin_port_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        offline_i = 1'b1;
    logic        cfg_master_i = 1'b1;
    logic [2:0]  cfg_cnt_m1_i = 3'd2;
    logic [3:0]  cfg_pol_i = 4'hF;
    logic        rd_i = 1'b0;
    logic [2:0]  sel_i = 3'd0;
    logic [7:0]  data_i = 8'd0;
    logic        last_i = 1'b0;
    logic        done_i = 1'b0;
    logic        ready_o, busy_o;
    logic [2:0]  next_idx_o;
    logic [63:0] var_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fzin_port_tb_top_dut: begin end

    fzin_port dut_i (
        .clk(clk), .rst_n(rst_n), .offline_i(offline_i),
        .cfg_master_i(cfg_master_i), .cfg_cnt_m1_i(cfg_cnt_m1_i),
        .cfg_pol_i(cfg_pol_i), .rd_i(rd_i), .sel_i(sel_i), .data_i(data_i),
        .last_i(last_i), .done_i(done_i), .ready_o(ready_o), .busy_o(busy_o),
        .next_idx_o(next_idx_o), .var_o(var_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic ack_act();
        return ~(ready_o ^ cfg_pol_i[0]);
    endfunction
    function automatic logic busy_act();
        return ~(busy_o ^ cfg_pol_i[3]);
    endfunction
    function automatic logic [7:0] slot(input int k);
        return var_o[k*8 +: 8];
    endfunction

    task automatic drive_rd(input logic act);
        rd_i = act ? cfg_pol_i[1] : ~cfg_pol_i[1];
    endtask
    task automatic drive_last(input logic act);
        last_i = act ? cfg_pol_i[2] : ~cfg_pol_i[2];
    endtask

    // one handshake; exp_ack says whether the byte should be accepted
    task automatic send(input logic [2:0] sel, input logic [7:0] d, input logic exp_ack);
        @(negedge clk);
        sel_i = sel; data_i = d; drive_rd(1'b1);
        @(negedge clk);
        chk("R3 ack not yet after E0", ack_act(), 1'b0);
        @(negedge clk);
        chk(exp_ack ? "R3 ack after E0+1" : "R8 no ack while busy", ack_act(), exp_ack);
        drive_rd(1'b0);
        @(negedge clk);
        chk("R3 ack released", ack_act(), 1'b0);
        @(negedge clk);
    endtask

    task automatic done_pulse();
        @(negedge clk); done_i = 1'b1;
        @(negedge clk); done_i = 1'b0;
        chk("R9 busy cleared by done", busy_act(), 1'b0);
        chk("R9 next index reopened at 0", next_idx_o, 3'd0);
    endtask

    task automatic last_pulse();
        @(negedge clk); drive_last(1'b1);
        @(negedge clk); drive_last(1'b0);
    endtask

    task automatic t_reset();
        chk("R1 ack inactive", ack_act(), 1'b0);
        chk("R1 busy inactive", busy_act(), 1'b0);
        chk("R1 next index", next_idx_o, 3'd0);
        chk("R1 slots cleared", var_o[31:0], 32'd0);
    endtask

    task automatic t_guard();
        @(negedge clk);
        offline_i = 1'b0; data_i = 8'h99; sel_i = 3'd0; drive_rd(1'b1);
        repeat (3) @(negedge clk);
        chk("R2 no ack in guard time", ack_act(), 1'b0);
        repeat (3) @(negedge clk);
        drive_rd(1'b0);
        @(negedge clk);
        chk("R2 nothing stored in guard time", slot(0), 8'h00);
        chk("R2 still idle", busy_act(), 1'b0);
    endtask

    task automatic t_master();
        send(3'd7, 8'h11, 1'b1);
        chk("R4 index after first byte", next_idx_o, 3'd1);
        send(3'd7, 8'h22, 1'b1);
        chk("R4 index after second byte", next_idx_o, 3'd2);
        chk("R4 not busy before count reached", busy_act(), 1'b0);
        send(3'd7, 8'h33, 1'b1);
        chk("R5 busy after last sequential byte", busy_act(), 1'b1);
        chk("R5 index wrapped", next_idx_o, 3'd0);
        chk("R4 slot0", slot(0), 8'h11);
        chk("R4 slot1", slot(1), 8'h22);
        chk("R4 slot2", slot(2), 8'h33);
    endtask

    task automatic t_busy_ignore();
        send(3'd0, 8'hEE, 1'b0);
        chk("R8 slot0 unchanged", slot(0), 8'h11);
        chk("R8 still busy", busy_act(), 1'b1);
    endtask

    task automatic t_slave();
        @(negedge clk); cfg_master_i = 1'b0;
        send(3'd5, 8'hA5, 1'b1);
        send(3'd1, 8'h5A, 1'b1);
        chk("R7 not busy before last strobe", busy_act(), 1'b0);
        last_pulse();
        chk("R7 busy after last strobe", busy_act(), 1'b1);
        chk("R6 slot5", slot(5), 8'hA5);
        chk("R6 slot1", slot(1), 8'h5A);
        chk("R7 slot0 kept", slot(0), 8'h11);
        chk("R7 slot2 kept", slot(2), 8'h33);
    endtask

    task automatic t_polarity();
        @(negedge clk);
        cfg_pol_i = 4'h0; rd_i = 1'b1; last_i = 1'b1;
        @(negedge clk);
        chk("R10 ack pin idle high when active low", ready_o, 1'b1);
        chk("R10 busy pin idle high when active low", busy_o, 1'b1);
        send(3'd3, 8'hC3, 1'b1);
        chk("R10 slot3 written by low request", slot(3), 8'hC3);
        last_pulse();
        chk("R10 busy pin low when active", busy_o, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_guard();
        t_master();
        t_busy_ignore();
        done_pulse();
        t_slave();
        done_pulse();
        t_polarity();
        done_pulse();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule